// File: doc/BRIEF.md
# Paged Effective-Address Unit

This block sits in the front of a small 12-bit accumulator processor. For each instruction word it works out the class of the opcode. For an instruction that references memory, it also forms the operand's effective address. An address inside an instruction only carries a 7-bit word number. A page-select bit places that word either in the fixed page zero or in the page that holds the instruction. An indirect bit can ask for one extra memory read, and the word returned by that read becomes the effective address.

The controlling pipeline presents an instruction together with its own address and pulses `start` while `idle` is high. The unit answers with a one-cycle `done` strobe. The strobe carries the class and the effective address. Direct and non-memory instructions finish in the cycle after `start`. An indirect reference first holds a read request open until the memory answers with `mem_valid`.

Top module: `paged_ea_unit`

## Requirements
- R1: After reset `idle` is 1, `done` is 0, `mem_req` is 0 and `opclass` is 0.
- R2: The opcode is `instr[11:9]`. Opcodes 0 to 5 give `opclass` 0 (memory reference), opcode 6 gives `opclass` 1 (input/output transfer) and opcode 7 gives `opclass` 2 (operate). The class is presented while `done` is high.
- R3: When the page bit `instr[7]` is 0, the formed address is the 7-bit field `instr[6:0]` with its upper 5 bits zero.
- R4: When the page bit is 1, the formed address is `pc[11:7]` followed by `instr[6:0]`.
- R5: For a memory reference with the indirect bit `instr[8]` at 0:
  - `done` rises in the cycle after `start`.
  - `ea` equals the formed address.
  - no memory read is made.
- R6: For a memory reference with the indirect bit at 1:
  - `mem_req` rises in the cycle after `start`, with `mem_addr` equal to the formed address.
  - Both stay unchanged until `mem_valid` is seen.
  - Exactly one read is completed per instruction.
- R7: When an indirect read completes:
  - `done` rises in the next cycle.
  - `ea` equals the `mem_rdata` word sampled with `mem_valid`.
  - `mem_req` is low again.
- R8: Opcodes 6 and 7 issue no memory read, raise `done` in the cycle after `start` and present `ea` as 0.
- R9: `start` has no effect unless `idle` is high. An instruction presented while a read is pending changes neither the read nor the result.
- R10: `done` is high for exactly one cycle, and the unit is back in the idle state in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Present a new instruction (taken only when idle) |
| instr | input | 12 | Instruction word |
| pc | input | 12 | Address of the instruction |
| idle | output | 1 | Unit can accept an instruction |
| mem_req | output | 1 | Indirect read request |
| mem_addr | output | 12 | Indirect read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 12 | Read data word |
| done | output | 1 | One-cycle result strobe |
| opclass | output | 2 | Opcode class (0 memory, 1 I/O, 2 operate) |
| ea | output | 12 | Effective address |

## Verification
The bench builds the unit with its defaults: a 12-bit word, a 3-bit opcode and a 7-bit in-page field. That is the only split in which the class boundary (opcodes 5, 6 and 7) and the 5-bit page number can both be reached from the ports. With these values the tests cover:
- page-boundary addresses such as offset 127 on the last page;
- indirect reads whose answer arrives after zero or several wait cycles;
- a second instruction offered while a read is still pending.

// File: rtl/paged_ea_pkg.sv
package paged_ea_pkg;
   typedef enum logic [1:0] {
      CLS_MEMREF = 2'd0,
      CLS_IO     = 2'd1,
      CLS_OPER   = 2'd2
   } op_class_e;
endpackage

// File: rtl/ea_decode.sv
module ea_decode
   import paged_ea_pkg::*;
#(
   parameter int WORD_W      = 12,
   parameter int OPC_W       = 3,
   parameter int OFF_W       = 7,
   parameter int LAST_MEMREF = 5,
   parameter int IO_OPC      = 6
) (
   input  logic [WORD_W-1:0] instr,
   input  logic [WORD_W-1:0] pc,
   output op_class_e         cls,
   output logic              indirect,
   output logic [WORD_W-1:0] addr
);
   localparam int HI_W    = WORD_W - OFF_W;
   localparam int IND_POS = WORD_W - OPC_W - 1;
   localparam int PG_POS  = IND_POS - 1;

   initial begin
      assert (WORD_W == OPC_W + 2 + OFF_W)
         else $fatal(1, "ea_decode: field widths do not fill the word");
      assert (LAST_MEMREF < IO_OPC && IO_OPC < (1 << OPC_W))
         else $fatal(1, "ea_decode: opcode split out of range");
   end

   logic [OPC_W-1:0] opc;
   logic             page_sel;
   logic [OFF_W-1:0] offset;

   assign opc      = instr[WORD_W-1 -: OPC_W];
   assign indirect = instr[IND_POS];
   assign page_sel = instr[PG_POS];
   assign offset   = instr[OFF_W-1:0];

   always_comb begin
      if (int'(opc) <= LAST_MEMREF)  cls = CLS_MEMREF;
      else if (int'(opc) == IO_OPC)  cls = CLS_IO;
      else                           cls = CLS_OPER;
   end

   generate
      if (HI_W > 0) begin : g_paged
         logic [HI_W-1:0] page_no;
         assign page_no = page_sel ? pc[WORD_W-1:OFF_W] : '0;
         assign addr    = {page_no, offset};
      end else begin : g_flat
         assign addr = offset;
      end
   endgenerate
endmodule

// File: rtl/ea_seq.sv
module ea_seq
   import paged_ea_pkg::*;
#(
   parameter int WORD_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  op_class_e         cls,
   input  logic              indirect,
   input  logic [WORD_W-1:0] addr,
   input  logic              mem_valid,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              idle,
   output logic              done,
   output logic              mem_req,
   output logic [WORD_W-1:0] mem_addr,
   output op_class_e         cls_q,
   output logic [WORD_W-1:0] ea
);
   typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_DONE} state_e;
   state_e state;
   logic [WORD_W-1:0] addr_q, ea_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         addr_q <= '0;
         ea_q   <= '0;
         cls_q  <= CLS_MEMREF;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               cls_q  <= cls;
               addr_q <= addr;
               if (cls == CLS_MEMREF && indirect) begin
                  state <= ST_READ;
               end else begin
                  state <= ST_DONE;
                  ea_q  <= (cls == CLS_MEMREF) ? addr : '0;
               end
            end
            ST_READ: if (mem_valid) begin
               ea_q  <= mem_rdata;
               state <= ST_DONE;
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign idle     = (state == ST_IDLE);
   assign done     = (state == ST_DONE);
   assign mem_req  = (state == ST_READ);
   assign mem_addr = addr_q;
   assign ea       = ea_q;

   assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_valid |=> mem_req && $stable(mem_addr));
   assert_req_memref_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> cls_q == CLS_MEMREF);
   assert_read_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_valid |=> done && ea == $past(mem_rdata));
   assert_nomem_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done && cls_q != CLS_MEMREF |-> ea == '0);
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && idle);
   assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !idle && start |=> !(idle && !$past(done)));
endmodule

// File: rtl/paged_ea_unit.sv
module paged_ea_unit
   import paged_ea_pkg::*;
#(
   parameter int WORD_W      = 12,
   parameter int OPC_W       = 3,
   parameter int OFF_W       = 7,
   parameter int LAST_MEMREF = 5,
   parameter int IO_OPC      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] instr,
   input  logic [WORD_W-1:0] pc,
   output logic              idle,
   output logic              mem_req,
   output logic [WORD_W-1:0] mem_addr,
   input  logic              mem_valid,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              done,
   output logic [1:0]        opclass,
   output logic [WORD_W-1:0] ea
);
   op_class_e         dec_cls, seq_cls;
   logic              dec_ind;
   logic [WORD_W-1:0] dec_addr;

   ea_decode #(
      .WORD_W(WORD_W), .OPC_W(OPC_W), .OFF_W(OFF_W),
      .LAST_MEMREF(LAST_MEMREF), .IO_OPC(IO_OPC)
   ) u_decode (
      .instr(instr), .pc(pc),
      .cls(dec_cls), .indirect(dec_ind), .addr(dec_addr)
   );

   ea_seq #(.WORD_W(WORD_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cls(dec_cls), .indirect(dec_ind), .addr(dec_addr),
      .mem_valid(mem_valid), .mem_rdata(mem_rdata),
      .idle(idle), .done(done), .mem_req(mem_req), .mem_addr(mem_addr),
      .cls_q(seq_cls), .ea(ea)
   );

   assign opclass = seq_cls;

   assert_no_req_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req);
endmodule

// File: tb/paged_ea_unit_bench.sv
module paged_ea_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [11:0] instr = '0;
   logic [11:0] pc = '0;
   logic        mem_valid = 1'b0;
   logic [11:0] mem_rdata = '0;
   logic        idle, mem_req, done;
   logic [11:0] mem_addr, ea;
   logic [1:0]  opclass;

   int checks = 0;
   int fails  = 0;
   int reads  = 0;

   always #10 clk = ~clk;

   paged_ea_unit u_paged_ea_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc(pc),
      .idle(idle), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_valid(mem_valid), .mem_rdata(mem_rdata),
      .done(done), .opclass(opclass), .ea(ea)
   );

   always @(posedge clk) if (mem_req && mem_valid) reads++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] mk(input int opc, input bit ind, input bit pg,
                                      input int off);
      return {opc[2:0], ind, pg, off[6:0]};
   endfunction

   function automatic logic [11:0] formed(input bit pg, input logic [11:0] p,
                                          input int off);
      return pg ? {p[11:7], off[6:0]} : {5'd0, off[6:0]};
   endfunction

   // Direct or non-memory instruction: done expected one cycle after start.
   task automatic run_direct(input int opc, input bit pg, input int off,
                             input logic [11:0] p, input int exp_cls,
                             input logic [11:0] exp_ea, input string req);
      int r0;
      r0 = reads;
      @(negedge clk);
      chk(idle, "R9", idle, 1);
      start = 1'b1; instr = mk(opc, 1'b0, pg, off); pc = p;
      @(negedge clk);
      start = 1'b0;
      chk(done, req, done, 1);
      chk(opclass == exp_cls[1:0], "R2", opclass, exp_cls);
      chk(ea == exp_ea, req, ea, exp_ea);
      chk(!mem_req && reads == r0, req, reads - r0, 0);
      @(negedge clk);
      chk(!done && idle, "R10", done, 0);
   endtask

   task automatic t_reset();
      chk(idle, "R1", idle, 1);
      chk(!done, "R1", done, 0);
      chk(!mem_req, "R1", mem_req, 0);
      chk(opclass == 2'd0, "R1", opclass, 0);
   endtask

   task automatic t_classes();
      for (int o = 0; o < 8; o++) begin
         int c;
         c = (o <= 5) ? 0 : (o == 6) ? 1 : 2;
         run_direct(o, 1'b0, 7'h15 + o, 12'h3A5, c,
                    (o <= 5) ? formed(1'b0, 12'h3A5, 7'h15 + o) : 12'h000,
                    (o <= 5) ? "R5" : "R8");
      end
   endtask

   task automatic t_page_zero();
      run_direct(1, 1'b0, 7'h7F, 12'hFFF, 0, 12'h07F, "R3");
      run_direct(2, 1'b0, 7'h00, 12'hF80, 0, 12'h000, "R3");
   endtask

   task automatic t_current_page();
      run_direct(3, 1'b1, 7'h7F, 12'hFFF, 0, 12'hFFF, "R4");
      run_direct(4, 1'b1, 7'h01, 12'h57F, 0, 12'h501, "R4");
      run_direct(0, 1'b1, 7'h40, 12'h07F, 0, 12'h040, "R4");
   endtask

   // Indirect: read held for 'wait_n' cycles, optionally with a competing start.
   task automatic run_indirect(input int opc, input bit pg, input int off,
                               input logic [11:0] p, input int wait_n,
                               input logic [11:0] data, input bit poke);
      int r0;
      logic [11:0] fa;
      r0 = reads;
      fa = formed(pg, p, off);
      @(negedge clk);
      start = 1'b1; instr = mk(opc, 1'b1, pg, off); pc = p;
      @(negedge clk);
      start = 1'b0;
      chk(mem_req && !done, "R6", mem_req, 1);
      chk(mem_addr == fa, "R6", mem_addr, fa);
      for (int i = 0; i < wait_n; i++) begin
         if (poke) begin
            start = 1'b1; instr = mk(7, 1'b0, 1'b1, 7'h11); pc = 12'hABC;
         end
         @(negedge clk);
         start = 1'b0;
         chk(mem_req && mem_addr == fa, poke ? "R9" : "R6", mem_addr, fa);
      end
      mem_valid = 1'b1; mem_rdata = data;
      @(negedge clk);
      mem_valid = 1'b0; mem_rdata = 12'h000;
      chk(done, "R7", done, 1);
      chk(ea == data, "R7", ea, data);
      chk(opclass == 2'd0, "R2", opclass, 0);
      chk(!mem_req, "R7", mem_req, 0);
      chk(reads - r0 == 1, "R6", reads - r0, 1);
      @(negedge clk);
      chk(!done && idle, "R10", done, 0);
      if (poke) chk(!done && !mem_req, "R9", mem_req, 0);
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks + 1, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_classes();
      t_page_zero();
      t_current_page();
      run_indirect(0, 1'b0, 7'h22, 12'h800, 0, 12'hC3D, 1'b0);
      run_indirect(5, 1'b1, 7'h7F, 12'hFFF, 3, 12'h5A5, 1'b0);
      run_indirect(2, 1'b1, 7'h10, 12'h2B0, 4, 12'h0F0, 1'b1);
      run_direct(6, 1'b1, 7'h7F, 12'hFFF, 1, 12'h000, "R8");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule